// File: doc/BRIEF.md
# Interrupt Pin Request and Delivery Controller

This block keeps the pending-request state for a set of interrupt input pins and decides, pin by pin, whether a new request is forwarded to the interrupt fabric or folded into one already outstanding. Each pin is driven by an update strobe that carries the pin's new level. The strobe may repeat the level the pin already has. The per-pin routing entry supplies the mask, the trigger mode, the vector, the destination, the destination addressing mode and the delivery mode. The entry is held outside this block. The block holds the request bit, a remote-pending bit for level-triggered entries, and a delivered bit for edge-triggered entries.

Requests that survive the checks are queued per pin and offered one at a time on a valid/ready delivery port. When a transfer completes, the fabric reports on the same cycle how many targets accepted it. Every strobe returns a one-cycle status on that pin: 1 means the request went forward, or there was nothing to send; 0 means it was folded into an earlier request or blocked by the mask. A rewrite pulse for an entry clears its remote-pending bit. If the entry is level-triggered and its request is still standing, the pulse also retries delivery.

Top module: `pin_delivery_ctrl`

## Requirements
- R1: After reset the readback request vector, the remote-pending vector, the delivery valid and every status valid are all 0.
- R2: A strobe with level 1 on an unmasked edge-triggered pin (trigger bit 0) whose request bit was clear sets the request bit. It reports status 1 in the cycle after the strobe and offers one delivery for that pin.
- R3: A strobe with level 1 on an edge-triggered pin whose request bit is already set is folded. It reports status 0 and produces no delivery.
- R4: A strobe with level 0 clears the pin's request bit and reports status 1.
- R5: A strobe with level 1 on a level-triggered pin (trigger bit 1) whose remote-pending bit is set is folded. It reports status 0 and produces no delivery.
- R6: A strobe with level 1 on a masked pin (mask bit 1) sets the request bit but produces no delivery, and it reports status 0.
- R7: A completed delivery for a level-triggered pin sets that pin's remote-pending bit when the reported accept count is nonzero, and leaves it clear when the count is zero.
- R8: A completed edge-triggered delivery hides the pin from the readback vector (readback = request AND NOT delivered). The next level-1 strobe on that pin makes it visible again.
- R9: A rewrite pulse clears the entry's remote-pending bit. A level-triggered, unmasked entry with its request bit set is then offered for delivery again. An edge entry, or an entry with no request standing, produces no delivery.
- R10: When several pins are waiting, the lowest index is offered first and at most one transfer completes per cycle. While valid is high and ready is low, the offered pin and its payload stay unchanged, even when a lower pin becomes ready meanwhile.
- R11: The delivery payload carries the offered pin's vector, destination, addressing bit, delivery mode and trigger bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | NPINS | Per-pin update strobe |
| line_level | input | NPINS | New level for each strobed pin |
| ent_mask | input | NPINS | Entry mask bits |
| ent_level_trig | input | NPINS | 1 = level-triggered, 0 = edge-triggered |
| ent_vector | input | NPINS*VEC_W | Packed vectors, pin i at bits i*VEC_W |
| ent_dest | input | NPINS*DEST_W | Packed destinations |
| ent_logical | input | NPINS | Destination addressing bit |
| ent_dmode | input | NPINS*DMODE_W | Packed delivery modes |
| ent_rewrite | input | 1 | Entry rewrite pulse |
| ent_rewrite_pin | input | PIN_W | Pin whose entry was rewritten |
| dlv_valid | output | 1 | Delivery offer valid |
| dlv_ready | input | 1 | Fabric takes the offer |
| dlv_pin | output | PIN_W | Offered pin index |
| dlv_vector | output | VEC_W | Offered vector |
| dlv_dest | output | DEST_W | Offered destination |
| dlv_logical | output | 1 | Offered addressing bit |
| dlv_dmode | output | DMODE_W | Offered delivery mode |
| dlv_level | output | 1 | Offered trigger bit |
| dlv_accepts | input | CNT_W | Accept count, valid with the transfer |
| stat_valid | output | NPINS | Status valid, one cycle after a strobe |
| stat_sent | output | NPINS | 1 = forwarded or nothing to send, 0 = folded or masked |
| irr_view | output | NPINS | Request bits with delivered edge bits removed |
| remote_irr | output | NPINS | Remote-pending bits |

## Verification
The hardest case to reach is the hold rule of R10, where a lower-index pin becomes ready while a higher one is already being offered against a low ready. The stimulus holds ready low, raises the higher pin alone, waits until its offer is locked, then raises the lower pin and only afterwards releases ready. The expected order is higher first. A second pass raises both pins in one cycle to show the lowest-first choice. Folding by a set remote-pending bit is reached by first completing a level delivery with a nonzero accept count. A re-offer with a zero count then shows the other branch of R7.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // readback hides edge requests already handed to the fabric
  function automatic logic pd_view(input logic req, input logic delivered);
    return req & ~delivered;
  endfunction

  // edge: folding happens when the request bit would not change
  function automatic logic pd_edge_fold(input logic req_old);
    return req_old;
  endfunction

  // level: folding happens while the previous delivery is unacknowledged
  function automatic logic pd_level_fold(input logic remote_pend);
    return remote_pend;
  endfunction

  function automatic logic pd_fold(input logic level_trig, input logic req_old,
                                   input logic remote_pend);
    return level_trig ? pd_level_fold(remote_pend) : pd_edge_fold(req_old);
  endfunction

endpackage

// File: rtl/pd_pin_slot.sv
module pd_pin_slot
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic level,
  input  logic mask,
  input  logic level_trig,
  input  logic rewrite,
  input  logic grant_hs,
  input  logic accepted_nz,
  output logic req,
  output logic delivered,
  output logic remote_pend,
  output logic want,
  output logic stat_v,
  output logic stat_ok
);

  logic fold_now;
  assign fold_now = pd_fold(level_trig, req, remote_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req         <= 1'b0;
      delivered   <= 1'b0;
      remote_pend <= 1'b0;
      want        <= 1'b0;
      stat_v      <= 1'b0;
      stat_ok     <= 1'b0;
    end else begin
      stat_v <= strobe;
      // completed transfer
      if (grant_hs) begin
        want <= 1'b0;
        if (level_trig) begin
          if (accepted_nz) remote_pend <= 1'b1;
        end else begin
          delivered <= 1'b1;
        end
      end
      // entry rewrite takes precedence over a same-cycle transfer
      if (rewrite) begin
        remote_pend <= 1'b0;
        if (level_trig && req && !mask) want <= 1'b1;
      end
      // line update takes precedence over both
      if (strobe) begin
        if (!level) begin
          req     <= 1'b0;
          stat_ok <= 1'b1;
        end else begin
          req       <= 1'b1;
          delivered <= 1'b0;
          if (fold_now || mask) begin
            stat_ok <= 1'b0;
          end else begin
            stat_ok <= 1'b1;
            want    <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pd_arb.sv
module pd_arb #(
  parameter int NPINS = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] req,
  input  logic             ready,
  output logic             valid,
  output logic [PIN_W-1:0] pin,
  output logic             fresh
);

  logic             held_v;
  logic [PIN_W-1:0] held_pin;

  function automatic logic [PIN_W-1:0] first_set(input logic [NPINS-1:0] v);
    logic [PIN_W-1:0] r;
    r = '0;
    for (int k = NPINS - 1; k >= 0; k--) begin
      if (v[k]) r = PIN_W'(k);
    end
    return r;
  endfunction

  assign valid = held_v | (|req);
  assign pin   = held_v ? held_pin : first_set(req);
  assign fresh = valid & ~held_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v   <= 1'b0;
      held_pin <= '0;
    end else if (valid && !ready) begin
      held_v   <= 1'b1;
      held_pin <= pin;
    end else begin
      held_v   <= 1'b0;
    end
  end

endmodule

// File: rtl/pin_delivery_ctrl.sv
module pin_delivery_ctrl
  import pd_pkg::*;
#(
  parameter int NPINS   = 8,
  parameter int VEC_W   = 8,
  parameter int DEST_W  = 8,
  parameter int DMODE_W = 3,
  parameter int CNT_W   = 4,
  localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          line_strobe,
  input  logic [NPINS-1:0]          line_level,
  input  logic [NPINS-1:0]          ent_mask,
  input  logic [NPINS-1:0]          ent_level_trig,
  input  logic [NPINS*VEC_W-1:0]    ent_vector,
  input  logic [NPINS*DEST_W-1:0]   ent_dest,
  input  logic [NPINS-1:0]          ent_logical,
  input  logic [NPINS*DMODE_W-1:0]  ent_dmode,
  input  logic                      ent_rewrite,
  input  logic [PIN_W-1:0]          ent_rewrite_pin,
  output logic                      dlv_valid,
  input  logic                      dlv_ready,
  output logic [PIN_W-1:0]          dlv_pin,
  output logic [VEC_W-1:0]          dlv_vector,
  output logic [DEST_W-1:0]         dlv_dest,
  output logic                      dlv_logical,
  output logic [DMODE_W-1:0]        dlv_dmode,
  output logic                      dlv_level,
  input  logic [CNT_W-1:0]          dlv_accepts,
  output logic [NPINS-1:0]          stat_valid,
  output logic [NPINS-1:0]          stat_sent,
  output logic [NPINS-1:0]          irr_view,
  output logic [NPINS-1:0]          remote_irr
);

  // named internal events, also used by the checker
  logic [NPINS-1:0] pin_irr;
  logic [NPINS-1:0] pin_dlvd;
  logic [NPINS-1:0] pin_want;
  logic [NPINS-1:0] pend_req;
  logic             dlv_fire;
  logic             arb_fresh;
  logic             acc_nz;

  assign dlv_fire = dlv_valid & dlv_ready;
  assign acc_nz   = |dlv_accepts;
  assign pend_req = pin_want & ~ent_mask;

  for (genvar i = 0; i < NPINS; i++) begin : g_slot
    logic rw_hit;
    logic hs_hit;
    assign rw_hit = ent_rewrite && (ent_rewrite_pin == PIN_W'(i));
    assign hs_hit = dlv_fire && (dlv_pin == PIN_W'(i));

    pd_pin_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (line_strobe[i]),
      .level       (line_level[i]),
      .mask        (ent_mask[i]),
      .level_trig  (ent_level_trig[i]),
      .rewrite     (rw_hit),
      .grant_hs    (hs_hit),
      .accepted_nz (acc_nz),
      .req         (pin_irr[i]),
      .delivered   (pin_dlvd[i]),
      .remote_pend (remote_irr[i]),
      .want        (pin_want[i]),
      .stat_v      (stat_valid[i]),
      .stat_ok     (stat_sent[i])
    );

    assign irr_view[i] = pd_view(pin_irr[i], pin_dlvd[i]);
  end

  pd_arb #(.NPINS(NPINS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend_req),
    .ready (dlv_ready),
    .valid (dlv_valid),
    .pin   (dlv_pin),
    .fresh (arb_fresh)
  );

  always_comb begin
    int sel;
    sel         = int'(dlv_pin);
    dlv_vector  = ent_vector[sel*VEC_W +: VEC_W];
    dlv_dest    = ent_dest[sel*DEST_W +: DEST_W];
    dlv_dmode   = ent_dmode[sel*DMODE_W +: DMODE_W];
    dlv_logical = ent_logical[sel];
    dlv_level   = ent_level_trig[sel];
  end

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int NPINS = 8,
  parameter int CNT_W = 4,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] line_strobe,
  input logic [NPINS-1:0] line_level,
  input logic [NPINS-1:0] ent_mask,
  input logic [NPINS-1:0] ent_level_trig,
  input logic             ent_rewrite,
  input logic [PIN_W-1:0] ent_rewrite_pin,
  input logic [NPINS-1:0] pin_irr,
  input logic [NPINS-1:0] remote_irr,
  input logic [NPINS-1:0] stat_valid,
  input logic [NPINS-1:0] stat_sent,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [PIN_W-1:0] dlv_pin,
  input logic             dlv_level,
  input logic [CNT_W-1:0] dlv_accepts,
  input logic             arb_fresh
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r3_edge_fold: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe[i] && line_level[i] && !ent_level_trig[i] && pin_irr[i]
      |=> stat_valid[i] && !stat_sent[i]);

    a_r4_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe[i] && !line_level[i] |=> !pin_irr[i] && stat_sent[i]);

    a_r5_level_fold: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe[i] && line_level[i] && ent_level_trig[i] && remote_irr[i]
      |=> stat_valid[i] && !stat_sent[i]);

    a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe[i] && line_level[i] && ent_mask[i]
      |=> !stat_sent[i] && pin_irr[i]);
  end

  a_r6_no_masked_offer: assert property (@(posedge clk) disable iff (!rst_n)
    arb_fresh |-> !ent_mask[dlv_pin]);

  a_r7_remote_set: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ready && dlv_level && (dlv_accepts != '0)
      && !(ent_rewrite && ent_rewrite_pin == dlv_pin)
    |=> remote_irr[$past(dlv_pin)]);

  a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin));

endmodule

bind pin_delivery_ctrl pd_checker #(.NPINS(NPINS), .CNT_W(CNT_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .line_strobe     (line_strobe),
  .line_level      (line_level),
  .ent_mask        (ent_mask),
  .ent_level_trig  (ent_level_trig),
  .ent_rewrite     (ent_rewrite),
  .ent_rewrite_pin (ent_rewrite_pin),
  .pin_irr         (pin_irr),
  .remote_irr      (remote_irr),
  .stat_valid      (stat_valid),
  .stat_sent       (stat_sent),
  .dlv_valid       (dlv_valid),
  .dlv_ready       (dlv_ready),
  .dlv_pin         (dlv_pin),
  .dlv_level       (dlv_level),
  .dlv_accepts     (dlv_accepts),
  .arb_fresh       (arb_fresh)
);

// File: tb/pin_delivery_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_delivery_ctrl_tb_top;
  localparam int N = 8;
  localparam int V = 8;
  localparam int D = 8;
  localparam int M = 3;
  localparam int C = 4;
  localparam int PW = 3;

  typedef struct packed {
    logic [PW-1:0] pin;
    logic [V-1:0]  vec;
    logic [D-1:0]  dst;
    logic          lg;
    logic [M-1:0]  dm;
    logic          lvl;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_strobe = '0, line_level = '0, ent_mask = '0, ent_level_trig = '0;
  logic [N*V-1:0] ent_vector = '0;
  logic [N*D-1:0] ent_dest = '0;
  logic [N-1:0] ent_logical = '0;
  logic [N*M-1:0] ent_dmode = '0;
  logic ent_rewrite = 1'b0;
  logic [PW-1:0] ent_rewrite_pin = '0;
  logic dlv_valid, dlv_ready = 1'b1;
  logic [PW-1:0] dlv_pin;
  logic [V-1:0] dlv_vector;
  logic [D-1:0] dlv_dest;
  logic dlv_logical, dlv_level;
  logic [M-1:0] dlv_dmode;
  logic [C-1:0] dlv_accepts = '0;
  logic [N-1:0] stat_valid, stat_sent, irr_view, remote_irr;

  int checks = 0;
  int failures = 0;
  item_t expq[$];

  always #2 clk = ~clk;

  pin_delivery_ctrl #(.NPINS(N), .VEC_W(V), .DEST_W(D), .DMODE_W(M), .CNT_W(C)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic item_t expect_of(int p);
    item_t it;
    it.pin = PW'(p);
    it.vec = V'(8'h40 + p);
    it.dst = D'(8'h10 * p + 1);
    it.lg  = p[0];
    it.dm  = M'(p);
    it.lvl = (p == 3 || p == 4);
    return it;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(logic [N-1:0] pins, logic [N-1:0] lv);
    line_strobe = pins;
    line_level  = lv;
    tick(1);
    line_strobe = '0;
  endtask

  task automatic rewrite(int p);
    ent_rewrite = 1'b1;
    ent_rewrite_pin = PW'(p);
    tick(1);
    ent_rewrite = 1'b0;
  endtask

  // monitor: pops expected transfers as the design completes them
  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      if (expq.size() == 0) begin
        chk("R10 unexpected transfer pin", 32'(dlv_pin), 32'hFFFF);
      end else begin
        item_t e;
        item_t a;
        e = expq.pop_front();
        a = '{dlv_pin, dlv_vector, dlv_dest, dlv_logical, dlv_dmode, dlv_level};
        chk("R11 payload", 32'(a), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      item_t it;
      it = expect_of(i);
      ent_vector[i*V +: V] = it.vec;
      ent_dest[i*D +: D]   = it.dst;
      ent_logical[i]       = it.lg;
      ent_dmode[i*M +: M]  = it.dm;
      ent_level_trig[i]    = it.lvl;
    end
    ent_mask[6] = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 irr_view", 32'(irr_view), 0);
    chk("R1 remote_irr", 32'(remote_irr), 0);
    chk("R1 dlv_valid", 32'(dlv_valid), 0);
    chk("R1 stat_valid", 32'(stat_valid), 0);
    rst_n = 1'b1;
    tick(2);

    // R2 edge raise delivers
    expq.push_back(expect_of(1));
    strobe(8'h02, 8'h02);
    chk("R2 status valid", 32'(stat_valid[1]), 1);
    chk("R2 status sent", 32'(stat_sent[1]), 1);
    tick(3);
    chk("R8 delivered hidden", 32'(irr_view[1]), 0);
    // R3 repeat raise folded, delivered cleared
    strobe(8'h02, 8'h02);
    chk("R3 status", 32'(stat_sent[1]), 0);
    tick(3);
    chk("R8 visible again", 32'(irr_view[1]), 1);
    chk("R3 no transfer", expq.size(), 0);
    // R4 low clears
    strobe(8'h02, 8'h00);
    chk("R4 status", 32'(stat_sent[1]), 1);
    chk("R4 irr", 32'(irr_view[1]), 0);

    // R6 masked pin
    strobe(8'h40, 8'h40);
    chk("R6 status", 32'(stat_sent[6]), 0);
    tick(3);
    chk("R6 irr kept", 32'(irr_view[6]), 1);
    chk("R6 dlv_valid", 32'(dlv_valid), 0);
    strobe(8'h40, 8'h40);
    chk("R3 masked refold", 32'(stat_sent[6]), 0);

    // R7 level delivery sets remote pending
    dlv_accepts = 4'd2;
    expq.push_back(expect_of(3));
    strobe(8'h08, 8'h08);
    chk("R2 level status", 32'(stat_sent[3]), 1);
    tick(3);
    chk("R7 remote set", 32'(remote_irr[3]), 1);
    chk("R8 level not hidden", 32'(irr_view[3]), 1);
    // R5 fold while remote pending
    strobe(8'h08, 8'h08);
    chk("R5 status", 32'(stat_sent[3]), 0);
    tick(3);
    chk("R5 no transfer", expq.size(), 0);

    // R9 rewrite retries, zero accepts keeps remote clear
    dlv_accepts = 4'd0;
    expq.push_back(expect_of(3));
    rewrite(3);
    tick(3);
    chk("R9 retried", expq.size(), 0);
    chk("R7 zero accepts", 32'(remote_irr[3]), 0);
    rewrite(1);
    rewrite(4);
    tick(3);
    chk("R9 no retry edge/idle", 32'(dlv_valid), 0);

    // R10 lowest first with ready low
    dlv_ready = 1'b0;
    expq.push_back(expect_of(2));
    expq.push_back(expect_of(5));
    strobe(8'h24, 8'h24);
    chk("R10 both status", 32'(stat_sent & 8'h24), 32'h24);
    tick(1);
    chk("R10 lowest offered", 32'(dlv_pin), 2);
    tick(3);
    chk("R10 held", 32'({dlv_valid, dlv_pin}), 32'h0A);
    dlv_ready = 1'b1;
    tick(4);
    chk("R10 order drained", expq.size(), 0);

    // R10 lock: higher pin offered first keeps its slot
    strobe(8'h24, 8'h00);
    dlv_ready = 1'b0;
    expq.push_back(expect_of(5));
    expq.push_back(expect_of(2));
    strobe(8'h20, 8'h20);
    tick(1);
    strobe(8'h04, 8'h04);
    tick(2);
    chk("R10 lock pin", 32'(dlv_pin), 5);
    dlv_ready = 1'b1;
    tick(5);
    chk("R10 lock drained", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule